// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Controller

This block gathers single-cycle interrupt event pulses from two independent groups, a bus-side group and a DMA-side group. It reports them to a host through visible status registers, one summary bit per group, an active-low interrupt pin and a halt output that stops a sequencer. Each event bit carries an enable and a class (fatal or nonfatal). A fatal condition is always recorded and always halts, even when its enable is off. A disabled nonfatal condition is only posted.

Each group has a second, hidden status level. While a group's summary bit is set, newly arriving conditions are absorbed into that hidden level and accumulate there. When the host clears the group with its clear strobe, the hidden contents are promoted into the visible level. The pin is held inactive for a guaranteed gap before it re-announces the promoted conditions. A pin-disable input stops all new assertions of the pin without cutting off one that is already active.

Top module: `stk_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset zeroes both levels of both groups, both summary bits and the gap timer, and leaves `irq_n` high and `halt` low.
- R2: When a group's summary bit is clear, an event bit that is enabled (enable input 1) is posted in that group's visible status and sets its summary bit in the same clock. `irq_n` falls one clock later.
- R3: An event bit whose class input is 1 (fatal) and whose enable is 0 still posts its status bit, sets the summary bit and raises `halt`, but never drives `irq_n` low.
- R4: An event bit with enable 0 and class 0 (disabled nonfatal) is ORed into the visible status at once, even while the summary bit is set. It never sets the summary bit and never enters the hidden level.
- R5: While a group's summary bit is set, enabled or fatal events go to that group's hidden level and leave its visible status unchanged.
- R6: Further events that arrive while both levels are occupied OR additional bits into the hidden level.
- R7: A clear strobe replaces the group's visible status with its hidden contents, zeroes the hidden level and sets the summary bit exactly when the promoted contents are non-zero.
- R8: After any clear strobe, `irq_n` is high for exactly GAP_CYC clocks (default 3). It then falls in the next clock if an enabled condition is pending at the visible level.
- R9: While `pin_dis` is 1, `irq_n` never falls. If `irq_n` is already low when `pin_dis` rises, it stays low until the next clear strobe.
- R10: The two groups keep separate summary bits. Clearing one group leaves the other group's status and summary unchanged.
- R11: An event that arrives in the same clock as its group's clear lands in the level that is free after the clear: the visible level if nothing was promoted, else the hidden level. It is never lost.
- R12: `halt` is high exactly while a fatal condition is held in either level of either group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scsi_evt | input | SCSI_W | Bus-side event pulses, one bit per condition |
| scsi_en | input | SCSI_W | Bus-side per-bit enable (1 = enabled) |
| scsi_fatal | input | SCSI_W | Bus-side per-bit class (1 = fatal) |
| scsi_clr | input | 1 | Host clear strobe for the bus-side group |
| dma_evt | input | DMA_W | DMA-side event pulses |
| dma_en | input | DMA_W | DMA-side per-bit enable |
| dma_fatal | input | DMA_W | DMA-side per-bit class |
| dma_clr | input | 1 | Host clear strobe for the DMA-side group |
| pin_dis | input | 1 | Blocks new assertions of the interrupt pin |
| scsi_stat | output | SCSI_W | Visible bus-side status |
| dma_stat | output | DMA_W | Visible DMA-side status |
| scsi_sum | output | 1 | Bus-side summary bit |
| dma_sum | output | 1 | DMA-side summary bit |
| irq_n | output | 1 | Interrupt pin, active low |
| halt | output | 1 | Halt request to the sequencer |

## Verification
Events are driven with an empty first level, with a pending first level (stacked), with both levels full (accumulating), and in the same clock as a clear, both with and without hidden contents. Together these separate the direct-capture, stacking, OR-accumulation and same-cycle placement paths. Each class and enable combination is driven separately, so a fatal disabled event (halt, no pin) can be told apart from a disabled nonfatal one (post only, no summary). The pin is followed cycle by cycle through the clear gap, and with `pin_dis` raised both while the pin is active and while it is idle.

// File: rtl/stk_irq_pkg.sv
package stk_irq_pkg;

    localparam int unsigned DEF_SCSI_W  = 16;
    localparam int unsigned DEF_DMA_W   = 8;
    localparam int unsigned DEF_GAP_CYC = 3;

    // Per-level occupancy flags carried alongside each status level
    typedef struct packed {
        logic pend;   // level holds a summary-raising condition
        logic pin;    // level holds an enabled condition (may drive the pin)
        logic fatal;  // level holds a fatal condition
    } lvl_flags_t;

    localparam lvl_flags_t FLAGS_NONE = '{pend: 1'b0, pin: 1'b0, fatal: 1'b0};

    typedef enum logic [1:0] {
        PIN_IDLE   = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_GAP    = 2'd2
    } pin_state_e;

    function automatic lvl_flags_t flags_merge(lvl_flags_t a, lvl_flags_t b);
        lvl_flags_t r;
        r.pend  = a.pend  | b.pend;
        r.pin   = a.pin   | b.pin;
        r.fatal = a.fatal | b.fatal;
        return r;
    endfunction

endpackage

// File: rtl/stk_irq_group.sv
module stk_irq_group
    import stk_irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    input  logic [W-1:0] fatal,
    input  logic         clr,
    output logic [W-1:0] stat,
    output logic         sum,
    output logic         pin_req,
    output logic         fatal_any
);

    logic [W-1:0] l1_q, l1_n;
    logic [W-1:0] l2_q, l2_n;
    lvl_flags_t   f1_q, f1_n;
    lvl_flags_t   f2_q, f2_n;

    logic [W-1:0] raise_v;
    logic [W-1:0] quiet_v;
    lvl_flags_t   new_f;

    // Classify incoming pulses
    always_comb begin
        raise_v     = evt & (en | fatal);
        quiet_v     = evt & ~en & ~fatal;
        new_f.pend  = |raise_v;
        new_f.pin   = |(evt & en);
        new_f.fatal = |(evt & fatal);
    end

    // Next-state: clear/promote first, then place new events in the free level
    always_comb begin
        l1_n = l1_q;
        l2_n = l2_q;
        f1_n = f1_q;
        f2_n = f2_q;
        if (clr) begin
            l1_n = l2_q;
            f1_n = f2_q;
            l2_n = '0;
            f2_n = FLAGS_NONE;
        end
        if (f1_n.pend) begin
            l2_n = l2_n | raise_v;
            f2_n = flags_merge(f2_n, new_f);
        end else begin
            l1_n = l1_n | raise_v;
            f1_n = flags_merge(f1_n, new_f);
        end
        l1_n = l1_n | quiet_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q <= '0;
            l2_q <= '0;
            f1_q <= FLAGS_NONE;
            f2_q <= FLAGS_NONE;
        end else begin
            l1_q <= l1_n;
            l2_q <= l2_n;
            f1_q <= f1_n;
            f2_q <= f2_n;
        end
    end

    assign stat      = l1_q;
    assign sum       = f1_q.pend;
    assign pin_req   = f1_q.pin;
    assign fatal_any = f1_q.fatal | f2_q.fatal;

    // R5: hidden level is only occupied while the visible level is pending
    p_stack_behind_r5: assert property (@(posedge clk) disable iff (rst)
        !f1_q.pend |-> (l2_q == '0))
        else $error("hidden level occupied with no pending summary");

    // R2: a set summary always has a visible status bit behind it
    p_sum_has_stat_r2: assert property (@(posedge clk) disable iff (rst)
        f1_q.pend |-> (l1_q != '0))
        else $error("summary set with empty status");

    // R5: visible bits are not lost while pending and not cleared
    p_hold_visible_r5: assert property (@(posedge clk) disable iff (rst)
        (f1_q.pend && !clr) |=> (($past(l1_q) & ~l1_q) == '0))
        else $error("visible status lost a bit while pending");

    // R7: a clear with no new events promotes the hidden level exactly
    p_promote_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> ((l1_q == $past(l2_q)) && (l2_q == '0)))
        else $error("promotion mismatch");

    // R4: only disabled nonfatal pulses cannot raise the summary
    p_quiet_no_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (!f1_q.pend && !clr && ((evt & (en | fatal)) == '0)) |=> !f1_q.pend)
        else $error("summary raised without an enabled or fatal event");

endmodule

// File: rtl/stk_irq_pin.sv
module stk_irq_pin
    import stk_irq_pkg::*;
#(
    parameter int unsigned GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic clr_any,
    input  logic pin_dis,
    output logic irq_n
);

    localparam int unsigned CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYC - 1);

    pin_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (clr_any) begin
            st_n  = PIN_GAP;
            cnt_n = GAP_LOAD;
        end else begin
            unique case (st_q)
                PIN_IDLE: begin
                    if (want && !pin_dis) st_n = PIN_ACTIVE;
                end
                PIN_ACTIVE: begin
                    if (!want) st_n = PIN_IDLE;
                end
                PIN_GAP: begin
                    if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
                    else if (want && !pin_dis) st_n = PIN_ACTIVE;
                    else st_n = PIN_IDLE;
                end
                default: st_n = PIN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PIN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign irq_n = (st_q != PIN_ACTIVE);

    // R8: the clock after a clear strobe always sees the pin released
    p_gap_after_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_any |=> irq_n)
        else $error("pin active right after clear");

    // R9: a disabled pin cannot fall
    p_dis_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_n && pin_dis) |=> irq_n)
        else $error("pin asserted while disabled");

    // R9: an active pin holds until serviced
    p_active_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !clr_any && want) |=> !irq_n)
        else $error("active pin dropped without service");

endmodule

// File: rtl/stk_irq_ctrl.sv
module stk_irq_ctrl
    import stk_irq_pkg::*;
#(
    parameter int unsigned SCSI_W  = DEF_SCSI_W,
    parameter int unsigned DMA_W   = DEF_DMA_W,
    parameter int unsigned GAP_CYC = DEF_GAP_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SCSI_W-1:0] scsi_evt,
    input  logic [SCSI_W-1:0] scsi_en,
    input  logic [SCSI_W-1:0] scsi_fatal,
    input  logic              scsi_clr,
    input  logic [DMA_W-1:0]  dma_evt,
    input  logic [DMA_W-1:0]  dma_en,
    input  logic [DMA_W-1:0]  dma_fatal,
    input  logic              dma_clr,
    input  logic              pin_dis,
    output logic [SCSI_W-1:0] scsi_stat,
    output logic [DMA_W-1:0]  dma_stat,
    output logic              scsi_sum,
    output logic              dma_sum,
    output logic              irq_n,
    output logic              halt
);

    logic scsi_pin, dma_pin;
    logic scsi_ftl, dma_ftl;

    stk_irq_group #(.W(SCSI_W)) u_scsi (
        .clk       (clk),
        .rst       (rst),
        .evt       (scsi_evt),
        .en        (scsi_en),
        .fatal     (scsi_fatal),
        .clr       (scsi_clr),
        .stat      (scsi_stat),
        .sum       (scsi_sum),
        .pin_req   (scsi_pin),
        .fatal_any (scsi_ftl)
    );

    stk_irq_group #(.W(DMA_W)) u_dma (
        .clk       (clk),
        .rst       (rst),
        .evt       (dma_evt),
        .en        (dma_en),
        .fatal     (dma_fatal),
        .clr       (dma_clr),
        .stat      (dma_stat),
        .sum       (dma_sum),
        .pin_req   (dma_pin),
        .fatal_any (dma_ftl)
    );

    stk_irq_pin #(.GAP_CYC(GAP_CYC)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .want    (scsi_pin | dma_pin),
        .clr_any (scsi_clr | dma_clr),
        .pin_dis (pin_dis),
        .irq_n   (irq_n)
    );

    assign halt = scsi_ftl | dma_ftl;

    // R12: a halt always has a pending summary in some group
    p_halt_has_sum_r12: assert property (@(posedge clk) disable iff (rst)
        halt |-> (scsi_sum | dma_sum))
        else $error("halt with no pending summary");

    // R3: the pin only falls when a summary is pending
    p_pin_needs_sum_r3: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (scsi_sum | dma_sum))
        else $error("pin active with nothing pending");

endmodule

// File: tb/test_stk_irq_ctrl.sv
`timescale 1ns/1ps
module test_stk_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] scsi_evt, scsi_en, scsi_fatal;
    logic [7:0]  dma_evt, dma_en, dma_fatal;
    logic        scsi_clr, dma_clr, pin_dis;
    logic [15:0] scsi_stat;
    logic [7:0]  dma_stat;
    logic        scsi_sum, dma_sum, irq_n, halt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] s;
        logic [7:0]  d;
        logic        ss;
        logic        sd;
        logic        irqn;
        logic        hlt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    stk_irq_ctrl i_stk_irq_ctrl (
        .clk(clk), .rst(rst),
        .scsi_evt(scsi_evt), .scsi_en(scsi_en), .scsi_fatal(scsi_fatal), .scsi_clr(scsi_clr),
        .dma_evt(dma_evt), .dma_en(dma_en), .dma_fatal(dma_fatal), .dma_clr(dma_clr),
        .pin_dis(pin_dis),
        .scsi_stat(scsi_stat), .dma_stat(dma_stat),
        .scsi_sum(scsi_sum), .dma_sum(dma_sum), .irq_n(irq_n), .halt(halt)
    );

    // Driver: apply one cycle of stimulus and queue the state expected after that edge
    task automatic step(input logic r, input logic [15:0] es, input logic [7:0] ed,
                        input logic cs, input logic cd,
                        input logic [15:0] xs, input logic [7:0] xd,
                        input logic xss, input logic xsd, input logic xirq, input logic xh,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; scsi_evt = es; dma_evt = ed; scsi_clr = cs; dma_clr = cd;
        e.s = xs; e.d = xd; e.ss = xss; e.sd = xsd; e.irqn = xirq; e.hlt = xh;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare shortly after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (scsi_stat !== e.s || dma_stat !== e.d || scsi_sum !== e.ss ||
                dma_sum !== e.sd || irq_n !== e.irqn || halt !== e.hlt) begin
                errors++;
                $display("FAIL %s: actual s=%h d=%h ss=%b sd=%b irq_n=%b halt=%b expected s=%h d=%h ss=%b sd=%b irq_n=%b halt=%b",
                         t, scsi_stat, dma_stat, scsi_sum, dma_sum, irq_n, halt,
                         e.s, e.d, e.ss, e.sd, e.irqn, e.hlt);
            end
        end
    end

    initial begin
        rst = 1'b1; scsi_evt = '0; dma_evt = '0; scsi_clr = 1'b0; dma_clr = 1'b0;
        pin_dis = 1'b0;
        scsi_en = 16'h00FF; scsi_fatal = 16'h8000;   // bit15 fatal disabled, bits 8..14 quiet
        dma_en  = 8'h0F;    dma_fatal  = 8'h80;      // bit7 fatal disabled
        //     rst es       ed     cs cd  stat_s   stat_d ss sd irqn halt
        step(1, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R1 reset");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R1 idle after reset");
        step(0, 16'h0001, 8'h00, 0, 0, 16'h0001, 8'h00, 1, 0, 1, 0, "R2 capture");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0001, 8'h00, 1, 0, 0, 0, "R2 pin falls");
        step(0, 16'h0002, 8'h00, 0, 0, 16'h0001, 8'h00, 1, 0, 0, 0, "R5 stacked");
        step(0, 16'h0004, 8'h00, 0, 0, 16'h0001, 8'h00, 1, 0, 0, 0, "R6 accumulate");
        step(0, 16'h0100, 8'h00, 0, 0, 16'h0101, 8'h00, 1, 0, 0, 0, "R4 quiet posted");
        step(0, 16'h0000, 8'h00, 1, 0, 16'h0006, 8'h00, 1, 0, 1, 0, "R7 promote");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0006, 8'h00, 1, 0, 1, 0, "R8 gap 2");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0006, 8'h00, 1, 0, 1, 0, "R8 gap 3");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0006, 8'h00, 1, 0, 0, 0, "R8 reassert");
        step(0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R7 clear empty stack");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R8 no reassert");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R8 no reassert");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R8 idle");
        step(0, 16'h8000, 8'h00, 0, 0, 16'h8000, 8'h00, 1, 0, 1, 1, "R3 fatal disabled");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h8000, 8'h00, 1, 0, 1, 1, "R3 no pin");
        step(0, 16'h0000, 8'h01, 0, 0, 16'h8000, 8'h01, 1, 1, 1, 1, "R10 dma capture");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h8000, 8'h01, 1, 1, 0, 1, "R10 pin");
        step(0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h01, 0, 1, 1, 0, "R10 R12 clear one group");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h01, 0, 1, 1, 0, "R8 gap");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h01, 0, 1, 1, 0, "R8 gap");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h01, 0, 1, 0, 0, "R8 other group reasserts");
        @(negedge clk); pin_dis = 1'b1;
        exp_q.push_back('{s:16'h0000, d:8'h01, ss:0, sd:1, irqn:0, hlt:0});
        tag_q.push_back("R9 active pin held");
        step(0, 16'h0000, 8'h02, 0, 0, 16'h0000, 8'h01, 0, 1, 0, 0, "R5 dma stacked");
        step(0, 16'h0000, 8'h04, 0, 1, 16'h0000, 8'h02, 0, 1, 1, 0, "R11 event with promote");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h02, 0, 1, 1, 0, "R9 gap");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h02, 0, 1, 1, 0, "R9 gap");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h02, 0, 1, 1, 0, "R9 blocked");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h02, 0, 1, 1, 0, "R9 still blocked");
        step(0, 16'h0000, 8'h00, 0, 1, 16'h0000, 8'h04, 0, 1, 1, 0, "R11 same-cycle event kept");
        step(0, 16'h0000, 8'h08, 0, 1, 16'h0000, 8'h08, 0, 1, 1, 0, "R11 event into free level");
        @(negedge clk); pin_dis = 1'b0;
        step(0, 16'h0000, 8'h00, 0, 1, 16'h0000, 8'h00, 0, 0, 1, 0, "R7 clear dma");
        step(0, 16'h0000, 8'h80, 0, 0, 16'h0000, 8'h80, 0, 1, 1, 1, "R12 dma fatal");
        step(0, 16'h0000, 8'h00, 0, 1, 16'h0000, 8'h00, 0, 0, 1, 0, "R12 halt drops");
        step(0, 16'h0000, 8'h01, 0, 0, 16'h0000, 8'h01, 0, 1, 1, 0, "R2 capture in gap");
        step(0, 16'h0000, 8'h80, 0, 0, 16'h0000, 8'h01, 0, 1, 1, 1, "R12 stacked fatal halts");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h01, 0, 1, 0, 1, "R8 pin after gap");
        step(0, 16'h0000, 8'h00, 0, 1, 16'h0000, 8'h80, 0, 1, 1, 1, "R7 R12 fatal promoted");
        step(0, 16'h0000, 8'h00, 0, 1, 16'h0000, 8'h00, 0, 0, 1, 0, "R12 all clear");
        step(0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, 0, 0, 1, 0, "R1 quiet end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule